// File: doc/BRIEF.md
# Reference-Assisted Frequency Lock Detector

This block supervises the clock-recovery loop of one receive channel. It counts edges of the recovered clock over a fixed window of local reference cycles. It compares that count with the count expected for the selected line rate and reference frequency, and from the result it decides whether the loop is in lock. It also drives the steering signal that makes the loop track either the local reference or the incoming data stream.

After reset the loop trains on the reference. Once the frequency has held inside tolerance for two measurement windows in a row, and the signal-present conditions are met, the block hands the loop to the data stream and clears its out-of-lock flag. A window outside tolerance while tracking data, a loss of signal, or a change of configuration sends the loop back to the reference. While the loop tracks the reference it still produces a usable recovered clock. The recovered-clock count crosses into the reference domain as a Gray code through a two-flop synchroniser.

Top module: `freqLockDetector`

## Requirements
- R1: During reset and right after it, `lolOut` is 1 (out of lock) and `loopSrcData` is 0 (loop on reference); `lolOut` is 1 exactly when `loopSrcData` is 0.
- R2: While tracking data, a window whose count lies outside tolerance returns the loop to the reference and raises `lolOut` on the cycle after the measurement completes.
- R3: After any restart the first window only primes the measurement. The loop is handed to data only when GOOD_WINDOWS (default 2) consecutive windows after that are in tolerance, so 2.5 windows after release `lolOut` is still 1.
- R4: The hand-over to data also requires `sigDetect`=1 and `losDigital`=0. While either condition fails the loop stays on the reference; once both hold and enough good windows have been seen, the hand-over occurs on the next cycle.
- R5: While tracking data, `sigDetect`=0 or `losDigital`=1 returns the loop to the reference and raises `lolOut` on the next clock.
- R6: The expected count per window of 2^WIN_LOG2 reference cycles is floor(2^WIN_LOG2 * K / 3), with K=2 for rate code 00 (51.84 Mbps), 6 for 01 (155.52 Mbps) and 24 for 10 or 11 (622.08 Mbps). K is multiplied by 4 when `refSel`=1 (19.44 MHz reference) instead of 0 (77.76 MHz). The tolerance is the expected count shifted right by TOL_SHIFT (default 11, about 490 ppm), with a minimum of 1.
- R7: For every rate code and reference selection, a data stream at nominal frequency keeps the loop on data. A stream about 1 % off is dropped back to the reference.
- R8: `chanDisable`=1 forces `lolOut`=1 and `loopSrcData`=0 on the next clock and holds the measurement idle. On release, acquisition starts again from the priming window.
- R9: A change of `rateSel` or `refSel` restarts the measurement and, if the loop was tracking data, returns it to the reference on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Local reference clock; all control logic runs on it |
| recClk | input | 1 | Recovered clock from the loop |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | 2 | Line-rate code: 00 low, 01 middle, 1x high rate |
| refSel | input | 1 | Reference frequency: 0 = 77.76 MHz, 1 = 19.44 MHz |
| sigDetect | input | 1 | External signal present, active high, synchronous to refClk |
| losDigital | input | 1 | Internal loss-of-signal status, active high, synchronous to refClk |
| chanDisable | input | 1 | Channel power-down; holds the lock logic idle |
| lolOut | output | 1 | 1 = out of lock, 0 = locked |
| loopSrcData | output | 1 | 1 = loop tracks the data stream, 0 = loop tracks the reference |

## Verification
The hardest case to reach from the ports is a measurement that fails only while the loop tracks data. With a nominal reference path, every acquisition succeeds first, so the fault appears only after the hand-over. The bench models the loop behaviourally: the recovered clock runs at the nominal period while `loopSrcData` is 0 and at a chosen data period once it is 1. An off-frequency data stream therefore locks first, then is measured and rejected two windows later, and the check is placed between that rejection and the earliest possible re-acquisition. Re-acquisition after a cleared loss of signal is reached by keeping the signal absent long enough for good windows to accumulate.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_REF  = 2'd1,
    ST_DATA = 2'd2
  } fldState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic enable;   // measurement windows run
    logic restart;  // drop the window in progress and prime again
  } fldStrobe_t;

  // recovered-clock edges per window for a rate code and reference choice
  function automatic longint unsigned expCount(input logic [1:0] rate,
                                               input logic refSel,
                                               input int winLog2);
    longint unsigned k;
    case (rate)
      2'b00:   k = 2;
      2'b01:   k = 6;
      default: k = 24;
    endcase
    if (refSel) k = k * 4;
    return (k << winLog2) / 3;
  endfunction

endpackage

// File: rtl/fldGrayCounter.sv
`timescale 1ns/1ps
module fldGrayCounter #(
  parameter int CNT_W = 19
) (
  input  logic             recClk,
  input  logic             rstN,
  output logic [CNT_W-1:0] grayQ
);
  logic [CNT_W-1:0] binQ;
  logic [CNT_W-1:0] binNext;

  assign binNext = binQ + 1'b1;

  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) begin
      binQ  <= '0;
      grayQ <= '0;
    end else begin
      binQ  <= binNext;
      grayQ <= binNext ^ (binNext >> 1);
    end
  end
endmodule

// File: rtl/fldDatapath.sv
`timescale 1ns/1ps
module fldDatapath
  import fld_pkg::*;
#(
  parameter int WIN_LOG2  = 12,
  parameter int TOL_SHIFT = 11,
  parameter int CNT_W     = 19
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] recGray,
  input  logic [1:0]       rateSel,
  input  logic             refSel,
  input  fldStrobe_t       strobe,
  output logic             measValid,
  output logic             inTol,
  output logic             cfgChanged
);
  localparam int CFG_N = 8;

  logic [CNT_W-1:0]    syncA, syncB;
  logic [CNT_W-1:0]    curBin, prevBin, delta, absDiff;
  logic [WIN_LOG2-1:0] wCnt;
  logic                primed, tick, tolOk;
  logic [2:0]          cfgQ, cfgNow;
  logic [CNT_W-1:0]    expTab [CFG_N];
  logic [CNT_W-1:0]    tolTab [CFG_N];
  logic [CNT_W-1:0]    expSel, tolSel;

  // expected count and tolerance for every {refSel, rateSel}
  for (genvar i = 0; i < CFG_N; i++) begin : g_tab
    localparam longint unsigned E  = expCount(2'(i % 4), 1'(i / 4), WIN_LOG2);
    localparam longint unsigned ES = E >> TOL_SHIFT;
    localparam longint unsigned T  = (ES == 0) ? 1 : ES;
    assign expTab[i] = CNT_W'(E);
    assign tolTab[i] = CNT_W'(T);
  end

  assign cfgNow     = {refSel, rateSel};
  assign expSel     = expTab[cfgNow];
  assign tolSel     = tolTab[cfgNow];
  assign cfgChanged = (cfgQ != cfgNow);

  always_comb begin
    curBin[CNT_W-1] = syncB[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) curBin[i] = curBin[i+1] ^ syncB[i];
  end

  assign delta   = curBin - prevBin;
  assign absDiff = (delta >= expSel) ? (delta - expSel) : (expSel - delta);
  assign tolOk   = (absDiff <= tolSel);
  assign tick    = strobe.enable && !strobe.restart && (wCnt == '1);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      cfgQ      <= '0;
      wCnt      <= '0;
      prevBin   <= '0;
      primed    <= 1'b0;
      measValid <= 1'b0;
      inTol     <= 1'b0;
    end else begin
      syncA <= recGray;
      syncB <= syncA;
      cfgQ  <= cfgNow;
      if (strobe.restart || !strobe.enable) begin
        wCnt      <= '0;
        primed    <= 1'b0;
        measValid <= 1'b0;
      end else begin
        wCnt      <= wCnt + 1'b1;
        measValid <= tick && primed;
        if (tick) begin
          prevBin <= curBin;
          primed  <= 1'b1;
          inTol   <= tolOk;
        end
      end
    end
  end
endmodule

// File: rtl/fldControl.sv
`timescale 1ns/1ps
module fldControl
  import fld_pkg::*;
#(
  parameter int GOOD_WINDOWS = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       measValid,
  input  logic       inTol,
  input  logic       cfgChanged,
  input  logic       sigDetect,
  input  logic       losDigital,
  input  logic       chanDisable,
  output fldStrobe_t strobe,
  output logic       lolOut,
  output logic       loopSrcData
);
  localparam int GOOD_W = $clog2(GOOD_WINDOWS + 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(GOOD_WINDOWS);

  fldState_e       state, nextState;
  logic [GOOD_W-1:0] goodCnt, nextGood, goodInc;
  logic            restart, sigOk;

  assign sigOk   = sigDetect && !losDigital;
  assign goodInc = (goodCnt == GOOD_MAX) ? goodCnt : goodCnt + 1'b1;

  always_comb begin
    nextState = state;
    nextGood  = goodCnt;
    restart   = 1'b0;
    case (state)
      ST_OFF: begin
        if (!chanDisable) begin
          nextState = ST_REF;
          restart   = 1'b1;
          nextGood  = '0;
        end
      end
      ST_REF: begin
        if (chanDisable) begin
          nextState = ST_OFF;
          nextGood  = '0;
        end else if (cfgChanged) begin
          restart  = 1'b1;
          nextGood = '0;
        end else begin
          if (measValid) nextGood = inTol ? goodInc : '0;
          if (nextGood == GOOD_MAX && sigOk) begin
            nextState = ST_DATA;
            restart   = 1'b1;
            nextGood  = '0;
          end
        end
      end
      ST_DATA: begin
        if (chanDisable) begin
          nextState = ST_OFF;
          nextGood  = '0;
        end else if (!sigOk || cfgChanged || (measValid && !inTol)) begin
          nextState = ST_REF;
          restart   = 1'b1;
          nextGood  = '0;
        end
      end
      default: begin
        nextState = ST_REF;
        restart   = 1'b1;
        nextGood  = '0;
      end
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_REF;
      goodCnt <= '0;
    end else begin
      state   <= nextState;
      goodCnt <= nextGood;
    end
  end

  assign strobe.enable  = (state != ST_OFF);
  assign strobe.restart = restart;
  assign lolOut         = (state != ST_DATA);
  assign loopSrcData    = (state == ST_DATA);
endmodule

// File: rtl/freqLockDetector.sv
`timescale 1ns/1ps
module freqLockDetector
  import fld_pkg::*;
#(
  parameter int WIN_LOG2     = 12,
  parameter int TOL_SHIFT    = 11,
  parameter int GOOD_WINDOWS = 2
) (
  input  logic       refClk,
  input  logic       recClk,
  input  logic       rstN,
  input  logic [1:0] rateSel,
  input  logic       refSel,
  input  logic       sigDetect,
  input  logic       losDigital,
  input  logic       chanDisable,
  output logic       lolOut,
  output logic       loopSrcData
);
  localparam int CNT_W = WIN_LOG2 + 7;

  logic [CNT_W-1:0] recGray;
  fldStrobe_t       strobe;
  logic             measValid, inTol, cfgChanged;

  fldGrayCounter #(.CNT_W(CNT_W)) u_cnt (
    .recClk (recClk),
    .rstN   (rstN),
    .grayQ  (recGray)
  );

  fldDatapath #(
    .WIN_LOG2  (WIN_LOG2),
    .TOL_SHIFT (TOL_SHIFT),
    .CNT_W     (CNT_W)
  ) u_dp (
    .refClk     (refClk),
    .rstN       (rstN),
    .recGray    (recGray),
    .rateSel    (rateSel),
    .refSel     (refSel),
    .strobe     (strobe),
    .measValid  (measValid),
    .inTol      (inTol),
    .cfgChanged (cfgChanged)
  );

  fldControl #(.GOOD_WINDOWS(GOOD_WINDOWS)) u_ctl (
    .refClk      (refClk),
    .rstN        (rstN),
    .measValid   (measValid),
    .inTol       (inTol),
    .cfgChanged  (cfgChanged),
    .sigDetect   (sigDetect),
    .losDigital  (losDigital),
    .chanDisable (chanDisable),
    .strobe      (strobe),
    .lolOut      (lolOut),
    .loopSrcData (loopSrcData)
  );
endmodule

// File: rtl/fldChecker.sv
`timescale 1ns/1ps
module fldChecker (
  input logic       refClk,
  input logic       rstN,
  input logic [1:0] rateSel,
  input logic       refSel,
  input logic       sigDetect,
  input logic       losDigital,
  input logic       chanDisable,
  input logic       measValid,
  input logic       inTol,
  input logic       lolOut,
  input logic       loopSrcData
);
  AST_DISABLE_IDLE: assert property (@(posedge refClk) disable iff (!rstN)
    chanDisable |=> (lolOut && !loopSrcData)); // R8

  AST_LOS_FALLBACK: assert property (@(posedge refClk) disable iff (!rstN)
    (!sigDetect || losDigital) |=> !loopSrcData); // R5

  AST_RISE_NEEDS_SIGNAL: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(loopSrcData) |-> $past(sigDetect && !losDigital)); // R4

  AST_BAD_WINDOW_DROP: assert property (@(posedge refClk) disable iff (!rstN)
    (loopSrcData && measValid && !inTol) |=> !loopSrcData); // R2

  AST_CFG_RESTART: assert property (@(posedge refClk) disable iff (!rstN)
    (!$stable(rateSel) || !$stable(refSel)) |=> !loopSrcData); // R9
endmodule

bind freqLockDetector fldChecker u_chk (
  .refClk      (refClk),
  .rstN        (rstN),
  .rateSel     (rateSel),
  .refSel      (refSel),
  .sigDetect   (sigDetect),
  .losDigital  (losDigital),
  .chanDisable (chanDisable),
  .measValid   (measValid),
  .inTol       (inTol),
  .lolOut      (lolOut),
  .loopSrcData (loopSrcData)
);

// File: tb/tb_freqLockDetector.sv
`timescale 1ns/1ps
module tb_freqLockDetector;
  localparam int WLOG = 10;
  localparam int W    = 1 << WLOG;

  typedef struct packed {
    logic [1:0]  rate;
    logic        refS;
    logic [15:0] dataPs;
    logic        lock;
  } vec_t;

  // nominal recovered periods: 00/0 6000, 01/0 2000, 1x/0 500, 00/1 1500, 01/1 500, 1x/1 125 ps
  localparam vec_t VECS [12] = '{
    '{2'b00, 1'b0, 16'd6000, 1'b1},
    '{2'b01, 1'b0, 16'd2000, 1'b1},
    '{2'b10, 1'b0, 16'd500,  1'b1},
    '{2'b11, 1'b1, 16'd125,  1'b1},
    '{2'b00, 1'b1, 16'd1500, 1'b1},
    '{2'b01, 1'b1, 16'd500,  1'b1},
    '{2'b00, 1'b0, 16'd6060, 1'b0},
    '{2'b01, 1'b0, 16'd2020, 1'b0},
    '{2'b11, 1'b0, 16'd505,  1'b0},
    '{2'b10, 1'b1, 16'd126,  1'b0},
    '{2'b00, 1'b1, 16'd1515, 1'b0},
    '{2'b01, 1'b1, 16'd505,  1'b0}
  };

  logic refClk = 1'b0;
  logic recClk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] rateSel = 2'b01;
  logic refSel = 1'b0;
  logic sigDetect = 1'b1;
  logic losDigital = 1'b0;
  logic chanDisable = 1'b0;
  logic lolOut, loopSrcData;

  int dataPs = 2000;
  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  bit done = 1'b0;

  freqLockDetector #(.WIN_LOG2(WLOG)) dut (
    .refClk(refClk), .recClk(recClk), .rstN(rstN), .rateSel(rateSel),
    .refSel(refSel), .sigDetect(sigDetect), .losDigital(losDigital),
    .chanDisable(chanDisable), .lolOut(lolOut), .loopSrcData(loopSrcData)
  );

  always #2 refClk = ~refClk;

  function automatic int nomPs(input logic [1:0] r, input logic s);
    int p;
    p = (r == 2'b00) ? 6000 : (r == 2'b01) ? 2000 : 500;
    return s ? p / 4 : p;
  endfunction

  // behavioural loop: reference-derived clock unless tracking data
  initial begin
    int p;
    int hi;
    #0.037;
    forever begin
      p  = loopSrcData ? dataPs : nomPs(rateSel, refSel);
      hi = p / 2;
      #(hi / 1000.0) recClk = 1'b1;
      #((p - hi) / 1000.0) recClk = 1'b0;
    end
  end

  always @(posedge refClk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge refClk);
    #1;
  endtask

  // act/exp = {lolOut, loopSrcData}
  task automatic chk(input string req, input logic [1:0] exp);
    nChecks++;
    if ({lolOut, loopSrcData} !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, {lolOut, loopSrcData}, exp);
    end
  endtask

  task automatic doReset;
    rstN = 1'b0;
    waitCyc(4);
    rstN = 1'b1;
  endtask

  initial begin
    // R1: reset state
    rstN = 1'b0;
    waitCyc(3);
    chk("R1 during reset", 2'b10);
    rstN = 1'b1;
    waitCyc(1);
    chk("R1 after release", 2'b10);
    // R3: priming window plus two good windows
    waitCyc(W * 5 / 2 - 1);
    chk("R3 no lock at 2.5 windows", 2'b10);
    waitCyc(W);
    chk("R3 lock at 3.5 windows", 2'b01);

    // R5 then R4: digital LOS
    losDigital = 1'b1;
    waitCyc(2);
    chk("R5 losDigital fallback", 2'b10);
    waitCyc(4 * W);
    chk("R4 held on reference during LOS", 2'b10);
    losDigital = 1'b0;
    waitCyc(3);
    chk("R4 reselect after LOS clears", 2'b01);

    // R5: external signal detect
    sigDetect = 1'b0;
    waitCyc(2);
    chk("R5 sigDetect fallback", 2'b10);
    sigDetect = 1'b1;
    waitCyc(2);
    chk("R3 no immediate reselect", 2'b10);
    waitCyc(W * 7 / 2);
    chk("R4 reselect after signal returns", 2'b01);

    // R9: configuration change
    rateSel = 2'b10;
    dataPs  = 500;
    waitCyc(2);
    chk("R9 rate change fallback", 2'b10);
    waitCyc(W * 7 / 2);
    chk("R6 relock at new rate", 2'b01);

    // R8: channel disable
    chanDisable = 1'b1;
    waitCyc(2);
    chk("R8 disable forces reference", 2'b10);
    waitCyc(4 * W);
    chk("R8 disable holds idle", 2'b10);
    chanDisable = 1'b0;
    waitCyc(W * 5 / 2);
    chk("R8 reacquire primes again", 2'b10);
    waitCyc(W);
    chk("R8 relock after enable", 2'b01);

    // R6 R7 R2: table of rate / reference / data frequency
    for (int i = 0; i < 12; i++) begin
      rateSel = VECS[i].rate;
      refSel  = VECS[i].refS;
      dataPs  = int'(VECS[i].dataPs);
      doReset();
      waitCyc(W * 7 / 2);
      chk("R6 reference path locks", 2'b01);
      waitCyc(2 * W);
      if (VECS[i].lock) chk("R7 nominal data holds lock", 2'b01);
      else              chk("R2 off-frequency data dropped", 2'b10);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule